// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block is the digital side of a group of pseudo open-drain pads. Each pin owns an output latch. A processor write strobe (active low) loads that latch. From the latch the block derives three pad enables per pin: a strong sink that pulls the pad low, a strong pull-up that is switched on for a short burst, and a weak keeper pull-up. A latch holding 0 keeps the sink on. When a latch rises from 0 to 1, the strong pull-up charges the pad quickly for a fixed number of clock periods. After that only the keeper holds the pad high, so an external device can still pull it down.

One parameter fixes the pin class for the whole group. Scan-output pins have no input path, and a read returns the latch. General-purpose pins always read the pad level. Port-style pins offer both a latch read and a pad read, chosen by a select input. Pad levels pass through a two-flop synchronizer before they reach the read data. The burst lasts two clock periods on scan-output and port-style pins and one period on general-purpose pins.

Top module: `qbio_port`

## Requirements
- R1: On a rising `clk` edge with `wr_n` low, each latch loads its `wr_data` bit. With `wr_n` high the latches hold and `wr_data` has no effect. A latch holding 0 asserts `sink_en` for that pin for as long as it holds 0.
- R2: On scan-output (class 0) and port-style (class 2) pins, a latch change from 0 to 1 asserts `strong_up_en` for exactly 2 clock cycles, starting with the cycle after the write edge.
- R3: On general-purpose pins (class 1), a latch change from 0 to 1 asserts `strong_up_en` for exactly 1 clock cycle, starting with the cycle after the write edge.
- R4: `sink_en` and `strong_up_en` are never both high on a pin. `weak_up_en` is high exactly when the pin is neither sinking nor in a burst.
- R5: Writing 1 to a latch that already holds 1 starts no burst.
- R6: Writing 0 during a burst ends the burst at that write edge and asserts `sink_en` in the same cycle.
- R7: On scan-output pins, `rd_data` equals the latch contents for either value of `rd_pin_sel`, whatever the pad level.
- R8: On general-purpose pins, `rd_data` equals `pin_in` delayed by two clock edges.
- R9: On port-style pins, `rd_data` is the latch when `rd_pin_sel`=0 and the pad level delayed by two clock edges when `rd_pin_sel`=1.
- R10: While `rst_n` is low at a clock edge, every latch is set to 1 and every burst is cleared. Afterwards `weak_up_en` is all ones, `sink_en` and `strong_up_en` are all zeros, and the synchronizer holds ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low latch write strobe |
| wr_data | input | NPINS | Data written to the latches |
| rd_pin_sel | input | 1 | Port-style read type: 1 pad level, 0 latch |
| pin_in | input | NPINS | Pad levels from the input buffers |
| rd_data | output | NPINS | Read data |
| sink_en | output | NPINS | Strong pull-down enable per pin |
| strong_up_en | output | NPINS | Strong pull-up burst enable per pin |
| weak_up_en | output | NPINS | Weak keeper pull-up enable per pin |

## Verification
The hardest cases to reach from the ports are writes that arrive while a burst is still running. Examples are a 0 written in the middle of a burst, or a 1 written over pins that are partly bursting and partly already high. Only a write whose timing matches the burst length exposes these cases. The bench sweeps every pair of old and new latch values for all three classes side by side, so every mix of rising, falling and steady pins is covered. It then holds the strobe low over consecutive edges, so the second write lands inside the burst.

// File: rtl/qbio_pkg.sv
// Shared types for the quasi-bidirectional port controller.
// Assumes: one pin class per instance, fixed at elaboration.
package qbio_pkg;
    typedef enum logic [1:0] {
        CLS_SCAN = 2'd0,
        CLS_GPIO = 2'd1,
        CLS_PORT = 2'd2
    } pin_class_e;

    // Burst length in clock periods for a class.
    function automatic int burst_for(pin_class_e cls, int long_len, int short_len);
        return (cls == CLS_GPIO) ? short_len : long_len;
    endfunction
endpackage

// File: rtl/qbio_pin_cell.sv
// One pin: output latch, burst counter and pad-enable decode.
// Assumes: wr_stb is already active high and synchronous to clk.
module qbio_pin_cell #(
    parameter int BURST_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic latch_q,
    output logic sink_en,
    output logic strong_en,
    output logic weak_en
);
    localparam int CW = $clog2(BURST_LEN + 1);

    logic [CW-1:0] cnt;

    // Latch update and burst counter: load on a 0-to-1 write, clear on a 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
            cnt     <= '0;
        end else begin
            if (wr_stb) begin
                latch_q <= wr_bit;
            end
            if (wr_stb && !wr_bit) begin
                cnt <= '0;
            end else if (wr_stb && wr_bit && !latch_q) begin
                cnt <= CW'(BURST_LEN);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Pad enables: sink while low, strong during burst, keeper otherwise.
    always_comb begin
        sink_en   = ~latch_q;
        strong_en = latch_q & (cnt != '0);
        weak_en   = latch_q & (cnt == '0);
    end
endmodule

// File: rtl/qbio_sync.sv
// Two-flop synchronizer for the pad levels.
// Assumes: pad inputs are asynchronous to clk; resets to all ones (pins idle high).
module qbio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qbio_rdmux.sv
// Read-data selection per pin class.
// Assumes: the class is constant; rd_pin_sel matters only for port-style pins.
module qbio_rdmux
    import qbio_pkg::*;
#(
    parameter int         W         = 4,
    parameter pin_class_e PIN_CLASS = CLS_SCAN
) (
    input  logic [W-1:0] latch_v,
    input  logic [W-1:0] pin_v,
    input  logic         rd_pin_sel,
    output logic [W-1:0] rd_data
);
    // Choose the latch or the synchronized pad level.
    always_comb begin
        case (PIN_CLASS)
            CLS_SCAN: rd_data = latch_v;
            CLS_GPIO: rd_data = pin_v;
            default:  rd_data = rd_pin_sel ? pin_v : latch_v;
        endcase
    end
endmodule

// File: rtl/qbio_port.sv
// Quasi-bidirectional pin group: latches, bursts, keeper and read path.
// Assumes: all pins share one class and one write strobe.
module qbio_port
    import qbio_pkg::*;
#(
    parameter int         NPINS     = 4,
    parameter pin_class_e PIN_CLASS = CLS_SCAN,
    parameter int         LONG_LEN  = 2,
    parameter int         SHORT_LEN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [NPINS-1:0] wr_data,
    input  logic             rd_pin_sel,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] rd_data,
    output logic [NPINS-1:0] sink_en,
    output logic [NPINS-1:0] strong_up_en,
    output logic [NPINS-1:0] weak_up_en
);
    localparam int BURST_LEN = burst_for(PIN_CLASS, LONG_LEN, SHORT_LEN);

    logic [NPINS-1:0] latch_v;
    logic [NPINS-1:0] pin_sync;
    logic             wr_stb;

    // Active-high version of the write strobe.
    always_comb wr_stb = ~wr_n;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        qbio_pin_cell #(.BURST_LEN(BURST_LEN)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stb    (wr_stb),
            .wr_bit    (wr_data[i]),
            .latch_q   (latch_v[i]),
            .sink_en   (sink_en[i]),
            .strong_en (strong_up_en[i]),
            .weak_en   (weak_up_en[i])
        );
    end

    qbio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    qbio_rdmux #(.W(NPINS), .PIN_CLASS(PIN_CLASS)) u_rdmux (
        .latch_v    (latch_v),
        .pin_v      (pin_sync),
        .rd_pin_sel (rd_pin_sel),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/qbio_port_chk.sv
// Property checker for qbio_port, bound to every instance.
// Assumes: reset is held for at least two clock edges.
module qbio_port_chk
    import qbio_pkg::*;
#(
    parameter int         NPINS     = 4,
    parameter pin_class_e PIN_CLASS = CLS_SCAN,
    parameter int         LONG_LEN  = 2,
    parameter int         SHORT_LEN = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_n,
    input logic [NPINS-1:0] wr_data,
    input logic             rd_pin_sel,
    input logic [NPINS-1:0] rd_data,
    input logic [NPINS-1:0] sink_en,
    input logic [NPINS-1:0] strong_up_en,
    input logic [NPINS-1:0] weak_up_en
);
    localparam int BURST_LEN = burst_for(PIN_CLASS, LONG_LEN, SHORT_LEN);

    assert_sink_follows_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_n) |-> sink_en == ~$past(wr_data));

    assert_hold_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_n) |-> sink_en == $past(sink_en));

    assert_sink_strong_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_en & strong_up_en) == '0);

    assert_keeper_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        weak_up_en == ~(sink_en | strong_up_en));

    assert_burst_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strong_up_en & ~$past(strong_up_en) & ~$past(sink_en)) == '0);

    if (BURST_LEN == 1) begin : g_short
        assert_burst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (strong_up_en & $past(strong_up_en)) == '0);
    end else begin : g_long
        assert_burst_max_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (strong_up_en & $past(strong_up_en) & $past(strong_up_en, 2)) == '0);
    end

    if (PIN_CLASS == CLS_SCAN) begin : g_scan
        assert_latch_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data == ~sink_en);
    end else if (PIN_CLASS == CLS_PORT) begin : g_port
        assert_latch_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_pin_sel |-> rd_data == ~sink_en);
    end
endmodule

bind qbio_port qbio_port_chk #(
    .NPINS(NPINS), .PIN_CLASS(PIN_CLASS), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(wr_data), .rd_pin_sel(rd_pin_sel),
    .rd_data(rd_data), .sink_en(sink_en), .strong_up_en(strong_up_en), .weak_up_en(weak_up_en)
);

// File: tb/sim_qbio_port.sv
`timescale 1ns/1ps
module sim_qbio_port;
    import qbio_pkg::*;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1;
    logic [N-1:0] wr_data = '0;
    logic rd_pin_sel = 1'b0;
    logic [N-1:0] pin_in = '1;
    logic [N-1:0] rd0, rd1, rd2, sk0, sk1, sk2, su0, su1, su2, wk0, wk1, wk2;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qbio_port #(.NPINS(N), .PIN_CLASS(CLS_SCAN)) u0 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .wr_data(wr_data), .rd_pin_sel(rd_pin_sel), .pin_in(pin_in), .rd_data(rd0),
        .sink_en(sk0), .strong_up_en(su0), .weak_up_en(wk0));
    qbio_port #(.NPINS(N), .PIN_CLASS(CLS_GPIO)) u1 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .wr_data(wr_data), .rd_pin_sel(rd_pin_sel), .pin_in(pin_in), .rd_data(rd1),
        .sink_en(sk1), .strong_up_en(su1), .weak_up_en(wk1));
    qbio_port #(.NPINS(N), .PIN_CLASS(CLS_PORT)) u2 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .wr_data(wr_data), .rd_pin_sel(rd_pin_sel), .pin_in(pin_in), .rd_data(rd2),
        .sink_en(sk2), .strong_up_en(su2), .weak_up_en(wk2));

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Check the pad enables of all three instances at burst offset k after a write.
    task automatic chk_pads(int k, logic [N-1:0] lat, logic [N-1:0] rise);
        logic [N-1:0] s_long, s_short;
        s_long  = (k < 2) ? rise : '0;
        s_short = (k < 1) ? rise : '0;
        chk("R1 sink u0", sk0, ~lat);
        chk("R1 sink u1", sk1, ~lat);
        chk("R2 burst u0", su0, s_long);
        chk("R3 burst u1", su1, s_short);
        chk("R2 burst u2", su2, s_long);
        chk("R4 keeper u0", wk0, lat & ~s_long);
        chk("R4 keeper u1", wk1, lat & ~s_short);
        chk("R7 latch read u0", rd0, lat);
        chk("R9 latch read u2", rd2, lat);
    endtask

    task automatic write_once(logic [N-1:0] v);
        @(negedge clk);
        wr_n = 1'b0;
        wr_data = v;
        @(negedge clk);
        wr_n = 1'b1;
        wr_data = ~v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: state after reset
        chk("R10 sink", sk0 | sk1 | sk2, '0);
        chk("R10 strong", su0 | su1 | su2, '0);
        chk("R10 keeper", wk0 & wk1 & wk2, '1);
        chk("R10 sync", rd1, '1);

        // R1 R2 R3 R4 R5 R7 R9: every old/new latch pair
        rd_pin_sel = 1'b0;
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                write_once(N'(o));
                repeat (3) @(negedge clk);
                write_once(N'(n));
                for (int k = 0; k < 3; k++) begin
                    chk_pads(k, N'(n), N'(n) & ~N'(o));
                    @(negedge clk);
                end
            end
        end

        // R1: data with strobe high has no effect
        write_once(4'b1010);
        repeat (3) @(negedge clk);
        wr_data = 4'b0101;
        repeat (2) @(negedge clk);
        chk("R1 ignore strobe high", sk2, 4'b0101);

        // R6: zero written during a burst, strobe held over two edges
        write_once(4'b0000);
        @(negedge clk);
        wr_n = 1'b0;
        wr_data = 4'b1111;
        @(negedge clk);
        chk("R6 burst started", su2, 4'b1111);
        wr_data = 4'b0011;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R6 burst cut u2", su2, 4'b0011);
        chk("R6 sink u2", sk2, 4'b1100);
        chk("R6 sink u0", sk0, 4'b1100);
        // R5: burst not extended by rewriting ones
        chk("R5 no restart", su0, 4'b0011);
        @(negedge clk);
        chk("R5 burst ends", su0, 4'b0000);

        // R7 R8 R9: pad read path, two-edge latency
        write_once(4'b0110);
        rd_pin_sel = 1'b1;
        for (int p = 0; p < 16; p++) begin
            logic [N-1:0] prev;
            prev = rd1;
            pin_in = N'(p);
            @(negedge clk);
            chk("R8 one edge", rd1, prev);
            chk("R9 one edge", rd2, prev);
            @(negedge clk);
            chk("R8 pad read", rd1, N'(p));
            chk("R9 pad read", rd2, N'(p));
            chk("R7 pad ignored", rd0, 4'b0110);
        end
        rd_pin_sel = 1'b0;
        @(negedge clk);
        chk("R9 latch select", rd2, 4'b0110);

        // R10: reset again from a mixed state
        write_once(4'b0000);
        @(negedge clk);
        wr_n = 1'b0;
        wr_data = 4'b1111;
        rst_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 no burst", su0 | su2, '0);
        chk("R10 latch ones", rd0, '1);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=completion", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule